// File: doc/BRIEF.md
# Scan-Line Event and Load Trigger Unit

This block sits next to a display timing generator and watches the horizontal and vertical scan position it reports. When the scan reaches the start of a programmed line, the block records an event. Four independent line sources each have a sticky status bit. A mask selects which of them drive one combined, level-sensitive interrupt line. Software clears a status bit by writing a one to it through a separate clear register.

The same position watch also drives two load strobes. Each strobe is a single-cycle pulse on a line of its own choosing, once per frame. One strobe is meant for single-buffered register updates and the other for double-buffered ones. The logic that acts on these strobes lives elsewhere. A simple word-addressed write port and a combinational read port give access to the line settings, the mask, the status and the clear register.

A line setting of zero marks the first line of the frame. A source programmed with zero therefore signals the frame wrap, which is a vertical-blank event.

Top module: `line_event_unit`

## Requirements
- R1: After reset the status, mask, all line settings and both strobe lines read back as zero, and `irq`, `sb_load_pulse` and `db_load_pulse` are low.
- R2: Words 0 to 3 hold the trigger line of sources 0 to 3 in bits 28:16. A read of these words returns that field and zeros in every other bit.
- R3: Status bit i (word 4, bit i) sets on the clock edge at which the position is x = 0 and y equals the line of source i. It sets only when that condition begins. A position held at the match does not set the bit again after a clear.
- R4: A status bit stays set until a write to word 5 carries a 1 in that bit position. Zero bits in that write leave status unchanged, and word 5 reads as zero.
- R5: If an event and a clear reach the same status bit on the same edge, the bit ends up set.
- R6: Word 6 bits 3:0 form the mask. `irq` is high exactly when some status bit and its mask bit are both 1, and it stays high until that is no longer so.
- R7: Word 7 holds the double-buffer strobe line in bits 12:0 and the single-buffer strobe line in bits 28:16. Each strobe output is high for exactly one cycle, in the cycle after the edge at which the position is x = 0 on its line.
- R8: A source whose line is zero records its event only when the position wraps to x = 0, y = 0, and not on any other line of the frame.
- R9: Writes to the status word (word 4) have no effect on status or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_x | input | 13 | Current horizontal scan position |
| pos_y | input | 13 | Current vertical scan position |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Combined masked interrupt, level |
| sb_load_pulse | output | 1 | Single-buffer load strobe |
| db_load_pulse | output | 1 | Double-buffer load strobe |

## Verification
A position or a register write applied before a rising edge shows its result after that one edge. This holds for status, `irq` and both strobes, because each depends on a single register stage. Read data follows `reg_addr` within the same cycle. The bench therefore updates its reference model at each edge and compares every output 1 ns after the edge. Register reads are compared a further nanosecond later, well before the next edge.

// File: rtl/lev_pkg.sv
package lev_pkg;
  localparam int N_SRC   = 4;
  localparam int COORD_W = 13;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int HI_LSB  = 16;
  localparam int LO_LSB  = 0;

  typedef logic [COORD_W-1:0] coord_t;
  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [N_SRC-1:0]   src_vec_t;
  typedef logic [DATA_W-1:0]  word_t;

  localparam addr_t ADR_STATUS = addr_t'(N_SRC);
  localparam addr_t ADR_CLR    = addr_t'(N_SRC + 1);
  localparam addr_t ADR_MASK   = addr_t'(N_SRC + 2);
  localparam addr_t ADR_TRIG   = addr_t'(N_SRC + 3);

  function automatic word_t place_coord(input coord_t c, input int lsb);
    word_t r;
    r = '0;
    r[lsb +: COORD_W] = c;
    return r;
  endfunction
endpackage

// File: rtl/lev_line_match.sv
module lev_line_match
  import lev_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  coord_t pos_x,
  input  coord_t pos_y,
  input  coord_t line,
  output logic   evt
);
  logic hit;
  logic hit_d;
  logic hit_q;

  // Match holds for the whole time the scan sits at the line start.
  always_comb begin
    hit   = (pos_x == '0) && (pos_y == line);
    hit_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
    end
  end

  // Only the first cycle of a match counts as an event.
  assign evt = hit & ~hit_q;
endmodule

// File: rtl/lev_cfg_regs.sv
module lev_cfg_regs
  import lev_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  addr_t                     addr,
  input  word_t                     wdata,
  output logic [N_SRC-1:0][COORD_W-1:0] line,
  output src_vec_t                  mask,
  output coord_t                    sb_line,
  output coord_t                    db_line,
  output logic                      clr_en,
  output src_vec_t                  clr_bits
);
  logic [N_SRC-1:0][COORD_W-1:0] line_d, line_q;
  src_vec_t mask_d, mask_q;
  coord_t   sb_d, sb_q;
  coord_t   db_d, db_q;
  logic     cfg_we;
  logic     unused_wdata_bits;

  assign unused_wdata_bits = ^{wdata[DATA_W-1:HI_LSB+COORD_W],
                               wdata[HI_LSB-1:LO_LSB+COORD_W]};

  always_comb begin
    line_d = line_q;
    mask_d = mask_q;
    sb_d   = sb_q;
    db_d   = db_q;
    for (int i = 0; i < N_SRC; i++) begin
      if (addr == addr_t'(i)) begin
        line_d[i] = wdata[HI_LSB +: COORD_W];
      end
    end
    if (addr == ADR_MASK) begin
      mask_d = wdata[N_SRC-1:0];
    end
    if (addr == ADR_TRIG) begin
      sb_d = wdata[HI_LSB +: COORD_W];
      db_d = wdata[LO_LSB +: COORD_W];
    end
  end

  assign cfg_we = wr_en && (addr != ADR_STATUS) && (addr != ADR_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      mask_q <= '0;
      sb_q   <= '0;
      db_q   <= '0;
    end else if (cfg_we) begin
      line_q <= line_d;
      mask_q <= mask_d;
      sb_q   <= sb_d;
      db_q   <= db_d;
    end
  end

  assign line     = line_q;
  assign mask     = mask_q;
  assign sb_line  = sb_q;
  assign db_line  = db_q;
  assign clr_en   = wr_en && (addr == ADR_CLR);
  assign clr_bits = wdata[N_SRC-1:0];
endmodule

// File: rtl/lev_status_bank.sv
module lev_status_bank
  import lev_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr_en,
  input  src_vec_t clr_bits,
  input  src_vec_t evt,
  input  src_vec_t mask,
  output src_vec_t status,
  output logic     irq
);
  src_vec_t status_d, status_q;
  src_vec_t clr_vec;
  logic     status_we;

  // A new event is ORed in after the clear, so it survives a collision.
  always_comb begin
    clr_vec   = clr_en ? clr_bits : '0;
    status_d  = (status_q & ~clr_vec) | evt;
    status_we = clr_en || (evt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (status_we) begin
      status_q <= status_d;
    end
  end

  assign status = status_q;
  assign irq    = |(status_q & mask);
endmodule

// File: rtl/lev_load_pulse.sv
module lev_load_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic sb_evt,
  input  logic db_evt,
  output logic sb_pulse,
  output logic db_pulse
);
  logic sb_d, sb_q;
  logic db_d, db_q;

  always_comb begin
    sb_d = sb_evt;
    db_d = db_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb_q <= 1'b0;
      db_q <= 1'b0;
    end else begin
      sb_q <= sb_d;
      db_q <= db_d;
    end
  end

  assign sb_pulse = sb_q;
  assign db_pulse = db_q;
endmodule

// File: rtl/line_event_unit.sv
module line_event_unit
  import lev_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [12:0] pos_x,
  input  logic [12:0] pos_y,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        sb_load_pulse,
  output logic        db_load_pulse
);
  logic [N_SRC-1:0][COORD_W-1:0] src_line;
  src_vec_t src_mask;
  src_vec_t src_status;
  src_vec_t line_evt;
  coord_t   sb_line;
  coord_t   db_line;
  logic     clr_en;
  src_vec_t clr_bits;
  logic     sb_evt;
  logic     db_evt;

  lev_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .line     (src_line),
    .mask     (src_mask),
    .sb_line  (sb_line),
    .db_line  (db_line),
    .clr_en   (clr_en),
    .clr_bits (clr_bits)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    lev_line_match u_match (
      .clk   (clk),
      .rst_n (rst_n),
      .pos_x (pos_x),
      .pos_y (pos_y),
      .line  (src_line[g]),
      .evt   (line_evt[g])
    );
  end

  lev_line_match u_sb_match (
    .clk   (clk),
    .rst_n (rst_n),
    .pos_x (pos_x),
    .pos_y (pos_y),
    .line  (sb_line),
    .evt   (sb_evt)
  );

  lev_line_match u_db_match (
    .clk   (clk),
    .rst_n (rst_n),
    .pos_x (pos_x),
    .pos_y (pos_y),
    .line  (db_line),
    .evt   (db_evt)
  );

  lev_status_bank u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_en   (clr_en),
    .clr_bits (clr_bits),
    .evt      (line_evt),
    .mask     (src_mask),
    .status   (src_status),
    .irq      (irq)
  );

  lev_load_pulse u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .sb_evt   (sb_evt),
    .db_evt   (db_evt),
    .sb_pulse (sb_load_pulse),
    .db_pulse (db_load_pulse)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (reg_addr == addr_t'(i)) begin
        reg_rdata = place_coord(src_line[i], HI_LSB);
      end
    end
    case (reg_addr)
      ADR_STATUS: reg_rdata = word_t'(src_status);
      ADR_MASK:   reg_rdata = word_t'(src_mask);
      ADR_TRIG:   reg_rdata = place_coord(sb_line, HI_LSB) | place_coord(db_line, LO_LSB);
      default:    ;
    endcase
  end
endmodule

// File: rtl/lev_checker.sv
module lev_checker
  import lev_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [12:0] pos_x,
  input logic [12:0] pos_y,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        irq,
  input logic        sb_load_pulse,
  input logic        db_load_pulse,
  input src_vec_t    status,
  input src_vec_t    mask,
  input src_vec_t    evt,
  input coord_t      db_line
);
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((status & $past(evt)) == $past(evt))); // R5

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_CLR && evt == '0) |=> ((status & $past(reg_wdata[N_SRC-1:0])) == '0)); // R4

  AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == ADR_CLR) |=> ((status & $past(status)) == $past(status))); // R4

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status & mask) != '0)); // R6

  AST_SB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sb_load_pulse |=> !sb_load_pulse); // R7

  AST_DB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    db_load_pulse |=> !db_load_pulse); // R7

  AST_DB_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    db_load_pulse |-> ($past(pos_x) == '0 && $past(pos_y) == $past(db_line))); // R7
endmodule

bind line_event_unit lev_checker u_lev_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pos_x         (pos_x),
  .pos_y         (pos_y),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .irq           (irq),
  .sb_load_pulse (sb_load_pulse),
  .db_load_pulse (db_load_pulse),
  .status        (src_status),
  .mask          (src_mask),
  .evt           (line_evt),
  .db_line       (db_line)
);

// File: tb/test_line_event_unit.sv
`timescale 1ns/1ps
module test_line_event_unit;
  localparam int HT = 8;
  localparam int VT = 10;

  logic        clk;
  logic        rst_n;
  logic [12:0] pos_x;
  logic [12:0] pos_y;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        sb_load_pulse;
  logic        db_load_pulse;

  int total;
  int bad;
  int sb_seen;
  int db_seen;

  logic [12:0] m_line [4];
  logic [3:0]  m_mask;
  logic [3:0]  m_status;
  logic [3:0]  m_prev;
  logic [12:0] m_sb;
  logic [12:0] m_db;
  logic        m_prev_sb;
  logic        m_prev_db;
  logic        m_sbp;
  logic        m_dbp;

  line_event_unit i_line_event_unit (
    .clk           (clk),
    .rst_n         (rst_n),
    .pos_x         (pos_x),
    .pos_y         (pos_y),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .irq           (irq),
    .sb_load_pulse (sb_load_pulse),
    .db_load_pulse (db_load_pulse)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic at_line(input logic [12:0] x, input logic [12:0] y, input logic [12:0] ln);
    return (x == 13'd0) && (y == ln);
  endfunction

  function automatic logic exp_irq(input logic [3:0] st, input logic [3:0] mk);
    return |(st & mk);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    logic [3:0]  hitv;
    logic [3:0]  ev;
    logic        sbh, dbh;
    logic        w;
    logic [2:0]  a;
    logic [31:0] d;
    for (int i = 0; i < 4; i++) hitv[i] = at_line(pos_x, pos_y, m_line[i]);
    ev  = hitv & ~m_prev;
    sbh = at_line(pos_x, pos_y, m_sb);
    dbh = at_line(pos_x, pos_y, m_db);
    w = reg_wr; a = reg_addr; d = reg_wdata;
    @(posedge clk);
    #1;
    m_sbp     = sbh & ~m_prev_sb;
    m_dbp     = dbh & ~m_prev_db;
    m_prev_sb = sbh;
    m_prev_db = dbh;
    m_prev    = hitv;
    m_status  = (m_status & ~((w && a == 3'd5) ? d[3:0] : 4'd0)) | ev;
    if (w) begin
      if (a < 3'd4) m_line[a[1:0]] = d[28:16];
      if (a == 3'd6) m_mask = d[3:0];
      if (a == 3'd7) begin
        m_sb = d[28:16];
        m_db = d[12:0];
      end
    end
    chk("R6 irq", {31'd0, irq}, {31'd0, exp_irq(m_status, m_mask)});
    chk("R7 sb strobe", {31'd0, sb_load_pulse}, {31'd0, m_sbp});
    chk("R7 db strobe", {31'd0, db_load_pulse}, {31'd0, m_dbp});
    if (sb_load_pulse) sb_seen++;
    if (db_load_pulse) db_seen++;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic setpos(input int x, input int y);
    pos_x = 13'(x);
    pos_y = 13'(y);
  endtask

  task automatic walk(input int y0, input int y1, input bit rnd);
    for (int y = y0; y <= y1; y++) begin
      for (int x = 0; x < HT; x++) begin
        setpos(x, y);
        if (rnd && ($urandom % 12) == 0) begin
          reg_wr = 1'b1;
          case ($urandom % 4)
            0: begin reg_addr = 3'd5; reg_wdata = 32'($urandom % 16); end
            1: begin reg_addr = 3'd6; reg_wdata = 32'($urandom % 16); end
            2: begin reg_addr = 3'($urandom % 4); reg_wdata = {3'd0, 13'($urandom % VT), 16'd0}; end
            default: begin reg_addr = 3'd7; reg_wdata = {3'd0, 13'($urandom % VT), 3'd0, 13'($urandom % VT)}; end
          endcase
        end
        tick();
        reg_wr = 1'b0;
      end
      rd("R3 status vs model", 3'd4, {28'd0, m_status});
    end
  endtask

  initial begin
    #(5.0 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    total = 0; bad = 0; sb_seen = 0; db_seen = 0;
    for (int i = 0; i < 4; i++) m_line[i] = '0;
    m_mask = '0; m_status = '0; m_prev = '0; m_sb = '0; m_db = '0;
    m_prev_sb = 1'b0; m_prev_db = 1'b0; m_sbp = 1'b0; m_dbp = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    setpos(1, 1);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 sb", {31'd0, sb_load_pulse}, 32'd0);
    chk("R1 db", {31'd0, db_load_pulse}, 32'd0);
    for (int a = 0; a < 8; a++) rd("R1 regs zero", 3'(a), 32'd0);
    rst_n = 1'b1;

    // R2 line fields and masked readback
    wr(3'd0, {3'b111, 13'd3, 3'b111, 13'h1abc});
    wr(3'd1, {3'b101, 13'd0, 16'hffff});
    wr(3'd2, {3'b000, 13'd5, 16'h1234});
    wr(3'd3, {3'b010, 13'd7, 16'h0001});
    rd("R2 line0", 3'd0, {3'd0, 13'd3, 16'd0});
    rd("R2 line2", 3'd2, {3'd0, 13'd5, 16'd0});
    rd("R2 line3", 3'd3, {3'd0, 13'd7, 16'd0});

    // R3 and R8: full frame from the wrap sets every source
    walk(0, VT - 1, 1'b0);
    rd("R3 all set", 3'd4, 32'h0000000f);
    wr(3'd5, 32'h0000000f);
    rd("R4 cleared", 3'd4, 32'd0);
    rd("R4 clear reads zero", 3'd5, 32'd0);
    walk(1, VT - 1, 1'b0);
    rd("R8 no set without wrap", 3'd4, 32'h0000000d);
    setpos(0, 0);
    tick();
    rd("R8 set at wrap", 3'd4, 32'h0000000f);

    // R4 partial clear, R6 mask
    setpos(3, 0);
    wr(3'd5, 32'h00000005);
    rd("R4 partial clear", 3'd4, 32'h0000000a);
    wr(3'd6, 32'h00000005);
    chk("R6 irq low masked", {31'd0, irq}, 32'd0);
    wr(3'd6, 32'h00000008);
    chk("R6 irq high", {31'd0, irq}, 32'd1);
    wr(3'd5, 32'h0000000f);
    chk("R6 irq falls", {31'd0, irq}, 32'd0);

    // R9 write to status word ignored
    wr(3'd4, 32'h0000000f);
    rd("R9 status unchanged", 3'd4, 32'd0);
    chk("R9 irq unchanged", {31'd0, irq}, 32'd0);

    // R3 held match does not re-set after clear
    setpos(0, 5);
    repeat (4) tick();
    rd("R3 held set", 3'd4, 32'h00000004);
    wr(3'd5, 32'h00000004);
    repeat (3) tick();
    rd("R3 held no reset", 3'd4, 32'd0);

    // R5 event and clear on the same edge
    setpos(2, 5);
    tick();
    setpos(0, 5);
    wr(3'd5, 32'h00000004);
    rd("R5 set wins", 3'd4, 32'h00000004);

    // R7 strobes once per frame on their lines
    wr(3'd7, {3'd0, 13'd2, 3'd0, 13'd6});
    rd("R7 trig readback", 3'd7, {3'd0, 13'd2, 3'd0, 13'd6});
    sb_seen = 0; db_seen = 0;
    walk(0, VT - 1, 1'b0);
    chk("R7 sb per frame", 32'(sb_seen), 32'd1);
    chk("R7 db per frame", 32'(db_seen), 32'd1);

    // random frames
    for (int f = 0; f < 25; f++) walk(0, VT - 1, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule